// File: doc/BRIEF.md
# Mixer Volume Register Remapper

This block holds the mixer volume settings behind a host indirect-register write path. The host addresses two spaces: a legacy space of indexed registers and a small extended space. Two legacy indices, 18 and 19, form the left and right pair that normally sets the line/auxiliary input level. When the internal FM engine is active and software has set the remap-enable bit in extended register X4, writes to those two legacy indices are steered into the internal FM volume pair X6/X7. Line-input volume then comes from extended pair X0/X1 instead of the legacy pair.

Reads use the same steering as writes, so software reading back index 18 or 19 sees the value it just wrote, wherever that value landed. The block exposes the resolved line, auxiliary and FM volume pairs to the mixer and flags whether steering is currently active. The mixer and any gain arithmetic sit outside this block.

Top module: `mixvol_remap`

## Requirements
- R1: After reset, legacy registers 18 and 19 and extended registers X0, X1, X6 and X7 hold the mute value 0x9F. Every other register holds 0x00, so the remap-enable bit is 0.
- R2: `remap_on` is 1 exactly when input `ifm_on` is 1 and the remap-enable bit of X4 is 1.
- R3: While steering is active, a legacy-space write (`wr_space`=0) to index 18 stores into X6 and one to index 19 stores into X7. Legacy registers 18 and 19 keep their values.
- R4: While steering is inactive, legacy-space writes to 18 and 19 store into legacy registers 18 and 19, and X6/X7 keep their values.
- R5: An extended-space write (`wr_space`=1) to X6 or X7 always stores there, whatever the steering state. `fm_l`/`fm_r` always show X6/X7.
- R6: `line_l`/`line_r` show X0/X1 while steering is active and legacy 18/19 otherwise. `aux_l`/`aux_r` always show legacy 18/19.
- R7: `rd_data` returns the register that a write to the same space and index would reach. This includes the steering of legacy 18/19.
- R8: Extended-space indices 8 to 31 hold no register. A write there changes nothing, and a read there returns 0.
- R9: The remap-enable bit is bit 0 of X4, and no other bit of X4 enables steering. A write to X4 takes effect from the following clock edge.
- R10: A write becomes visible on the outputs and on readback one clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifm_on | input | 1 | Internal FM engine active |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_space | input | 1 | Write space: 0 legacy, 1 extended |
| wr_idx | input | 5 | Write index |
| wr_data | input | 8 | Write data |
| rd_space | input | 1 | Read space: 0 legacy, 1 extended |
| rd_idx | input | 5 | Read index |
| rd_data | output | 8 | Combinational readback |
| remap_on | output | 1 | Steering of legacy 18/19 active |
| line_l | output | 8 | Resolved line-input volume, left |
| line_r | output | 8 | Resolved line-input volume, right |
| aux_l | output | 8 | Auxiliary volume, left |
| aux_r | output | 8 | Auxiliary volume, right |
| fm_l | output | 8 | Internal FM volume, left |
| fm_r | output | 8 | Internal FM volume, right |

## Verification
On every cycle the assertions check where a write to 18/19 lands in each steering state. They also check that extended writes to the FM pair always take effect and that writes to empty extended indices disturb no output. The sweeps in the bench cover what needs a full model: every legacy index written in all four combinations of `ifm_on` and the X4 bit, readback of all 64 addresses after each write, and X4 values with the enable bit clear but other bits set.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

   localparam int unsigned LEG_PAIR_L = 18;
   localparam int unsigned LEG_PAIR_R = 19;
   localparam int unsigned XLINE_L    = 0;
   localparam int unsigned XLINE_R    = 1;
   localparam int unsigned XCTRL      = 4;
   localparam int unsigned XFM_L      = 6;
   localparam int unsigned XFM_R      = 7;
   localparam int unsigned EXT_MIN    = 8;
   localparam int unsigned LEG_MIN    = 20;

   typedef enum logic {
      SPACE_LEG = 1'b0,
      SPACE_EXT = 1'b1
   } space_e;

   // volume registers that come out of reset muted
   function automatic logic is_vol(input logic ext, input int unsigned idx);
      if (ext)
         return (idx == XLINE_L) || (idx == XLINE_R) || (idx == XFM_L) || (idx == XFM_R);
      else
         return (idx == LEG_PAIR_L) || (idx == LEG_PAIR_R);
   endfunction

endpackage

// File: rtl/mvr_decode.sv
module mvr_decode
   import mvr_pkg::*;
#(
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned LEG_DEPTH = 32,
   parameter int unsigned EXT_DEPTH = 8
) (
   input  logic             space,
   input  logic [IDX_W-1:0] idx,
   input  logic             remap_on,
   output logic             leg_hit,
   output logic             ext_hit,
   output logic [IDX_W-1:0] tgt_idx
);

   localparam logic [IDX_W-1:0] IDX_L  = IDX_W'(LEG_PAIR_L);
   localparam logic [IDX_W-1:0] IDX_R  = IDX_W'(LEG_PAIR_R);
   localparam logic [IDX_W-1:0] FM_L   = IDX_W'(XFM_L);
   localparam logic [IDX_W-1:0] FM_R   = IDX_W'(XFM_R);

   logic [31:0] idx_w;
   assign idx_w = 32'(idx);

   always_comb begin
      leg_hit = 1'b0;
      ext_hit = 1'b0;
      tgt_idx = idx;
      if (space == SPACE_EXT) begin
         ext_hit = (idx_w < EXT_DEPTH);
      end else if (remap_on && (idx == IDX_L)) begin
         ext_hit = 1'b1;
         tgt_idx = FM_L;
      end else if (remap_on && (idx == IDX_R)) begin
         ext_hit = 1'b1;
         tgt_idx = FM_R;
      end else begin
         leg_hit = (idx_w < LEG_DEPTH);
      end
   end

endmodule

// File: rtl/mvr_regbank.sv
module mvr_regbank
   import mvr_pkg::*;
#(
   parameter int unsigned  DATA_W   = 8,
   parameter int unsigned  DEPTH    = 8,
   parameter int unsigned  IDX_W    = 5,
   parameter bit           IS_EXT   = 1'b0,
   parameter logic [DATA_W-1:0] MUTE_VAL = 8'h9F
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [IDX_W-1:0]             waddr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [IDX_W-1:0]             raddr,
   output logic [DEPTH-1:0][DATA_W-1:0] q,
   output logic [DATA_W-1:0]            rdata
);

   if (DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("mvr_regbank: DEPTH exceeds index range");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [DATA_W-1:0] RST_V =
         is_vol(IS_EXT, i) ? MUTE_VAL : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= RST_V;
         else if (we && (32'(waddr) == i))
            q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int unsigned k = 0; k < DEPTH; k++)
         if (32'(raddr) == k) rdata = q[k];
   end

endmodule

// File: rtl/mvr_route.sv
module mvr_route
   import mvr_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LEG_DEPTH = 32,
   parameter int unsigned EXT_DEPTH = 8,
   parameter int unsigned REMAP_BIT = 0
) (
   input  logic [LEG_DEPTH-1:0][DATA_W-1:0] leg_q,
   input  logic [EXT_DEPTH-1:0][DATA_W-1:0] ext_q,
   input  logic                             ifm_on,
   output logic                             remap_on,
   output logic [1:0][DATA_W-1:0]           line_v,
   output logic [1:0][DATA_W-1:0]           aux_v,
   output logic [1:0][DATA_W-1:0]           fm_v
);

   localparam int unsigned LEG_IX [2] = '{LEG_PAIR_L, LEG_PAIR_R};
   localparam int unsigned LIN_IX [2] = '{XLINE_L, XLINE_R};
   localparam int unsigned FM_IX  [2] = '{XFM_L, XFM_R};

   assign remap_on = ifm_on & ext_q[XCTRL][REMAP_BIT];

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      assign aux_v[ch]  = leg_q[LEG_IX[ch]];
      assign fm_v[ch]   = ext_q[FM_IX[ch]];
      assign line_v[ch] = remap_on ? ext_q[LIN_IX[ch]] : leg_q[LEG_IX[ch]];
   end

endmodule

// File: rtl/mixvol_remap.sv
module mixvol_remap
   import mvr_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned LEG_DEPTH = 32,
   parameter int unsigned EXT_DEPTH = 8,
   parameter int unsigned REMAP_BIT = 0,
   parameter logic [DATA_W-1:0] MUTE_VAL = 8'h9F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ifm_on,
   input  logic              wr_en,
   input  logic              wr_space,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_space,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              remap_on,
   output logic [DATA_W-1:0] line_l,
   output logic [DATA_W-1:0] line_r,
   output logic [DATA_W-1:0] aux_l,
   output logic [DATA_W-1:0] aux_r,
   output logic [DATA_W-1:0] fm_l,
   output logic [DATA_W-1:0] fm_r
);

   // elaboration-time parameter checks
   if (LEG_DEPTH < LEG_MIN) begin : g_chk_leg
      $error("mixvol_remap: LEG_DEPTH must cover indices 18 and 19");
   end
   if (EXT_DEPTH < EXT_MIN) begin : g_chk_ext
      $error("mixvol_remap: EXT_DEPTH must cover X0..X7");
   end
   if (REMAP_BIT >= DATA_W) begin : g_chk_bit
      $error("mixvol_remap: REMAP_BIT outside data word");
   end
   if (LEG_DEPTH > (1 << IDX_W)) begin : g_chk_idx
      $error("mixvol_remap: IDX_W too narrow for LEG_DEPTH");
   end

   logic [LEG_DEPTH-1:0][DATA_W-1:0] leg_q;
   logic [EXT_DEPTH-1:0][DATA_W-1:0] ext_q;
   logic [DATA_W-1:0] leg_rd, ext_rd;
   logic [1:0][DATA_W-1:0] line_v, aux_v, fm_v;

   logic             w_leg, w_ext, r_leg, r_ext;
   logic [IDX_W-1:0] w_tgt, r_tgt;

   mvr_decode #(.IDX_W(IDX_W), .LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_wdec (
      .space(wr_space), .idx(wr_idx), .remap_on(remap_on),
      .leg_hit(w_leg), .ext_hit(w_ext), .tgt_idx(w_tgt)
   );

   mvr_decode #(.IDX_W(IDX_W), .LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_rdec (
      .space(rd_space), .idx(rd_idx), .remap_on(remap_on),
      .leg_hit(r_leg), .ext_hit(r_ext), .tgt_idx(r_tgt)
   );

   mvr_regbank #(.DATA_W(DATA_W), .DEPTH(LEG_DEPTH), .IDX_W(IDX_W),
                 .IS_EXT(1'b0), .MUTE_VAL(MUTE_VAL)) u_leg (
      .clk(clk), .rst_n(rst_n), .we(wr_en & w_leg), .waddr(w_tgt),
      .wdata(wr_data), .raddr(r_tgt), .q(leg_q), .rdata(leg_rd)
   );

   mvr_regbank #(.DATA_W(DATA_W), .DEPTH(EXT_DEPTH), .IDX_W(IDX_W),
                 .IS_EXT(1'b1), .MUTE_VAL(MUTE_VAL)) u_ext (
      .clk(clk), .rst_n(rst_n), .we(wr_en & w_ext), .waddr(w_tgt),
      .wdata(wr_data), .raddr(r_tgt), .q(ext_q), .rdata(ext_rd)
   );

   mvr_route #(.DATA_W(DATA_W), .LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH),
               .REMAP_BIT(REMAP_BIT)) u_route (
      .leg_q(leg_q), .ext_q(ext_q), .ifm_on(ifm_on), .remap_on(remap_on),
      .line_v(line_v), .aux_v(aux_v), .fm_v(fm_v)
   );

   assign rd_data = r_leg ? leg_rd : (r_ext ? ext_rd : '0);
   assign line_l  = line_v[0];
   assign line_r  = line_v[1];
   assign aux_l   = aux_v[0];
   assign aux_r   = aux_v[1];
   assign fm_l    = fm_v[0];
   assign fm_r    = fm_v[1];

   // ---------------- assertions ----------------
   logic wr_leg18, wr_leg19, wr_oor;
   assign wr_leg18 = wr_en && (wr_space == SPACE_LEG) && (wr_idx == IDX_W'(LEG_PAIR_L));
   assign wr_leg19 = wr_en && (wr_space == SPACE_LEG) && (wr_idx == IDX_W'(LEG_PAIR_R));
   assign wr_oor   = wr_en && (wr_space == SPACE_EXT) && (32'(wr_idx) >= EXT_DEPTH);

   AST_STEER_TO_FM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_leg18 && remap_on) |=> (fm_l == $past(wr_data)) && $stable(aux_l)); // R3

   AST_STEER_TO_FM_R: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_leg19 && remap_on) |=> (fm_r == $past(wr_data)) && $stable(aux_r)); // R3

   AST_DIRECT_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_leg18 && !remap_on) |=> (aux_l == $past(wr_data)) && $stable(fm_l)); // R4

   AST_EXT_FM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_space == SPACE_EXT) && (wr_idx == IDX_W'(XFM_R))) |=> (fm_r == $past(wr_data))); // R5

   AST_EMPTY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_oor |=> $stable(line_l) && $stable(line_r) && $stable(aux_l) && $stable(aux_r)
                 && $stable(fm_l) && $stable(fm_r) && $stable(remap_on)); // R8

endmodule

// File: tb/tb_mixvol_remap.sv
module tb_mixvol_remap;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ifm_on = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_space = 1'b0;
   logic [4:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic       rd_space = 1'b0;
   logic [4:0] rd_idx = '0;
   logic [7:0] rd_data, line_l, line_r, aux_l, aux_r, fm_l, fm_r;
   logic       remap_on;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] mleg [32];
   logic [7:0] mext [8];

   always #5 clk = ~clk;

   mixvol_remap dut (
      .clk(clk), .rst_n(rst_n), .ifm_on(ifm_on), .wr_en(wr_en),
      .wr_space(wr_space), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_space(rd_space), .rd_idx(rd_idx), .rd_data(rd_data),
      .remap_on(remap_on), .line_l(line_l), .line_r(line_r),
      .aux_l(aux_l), .aux_r(aux_r), .fm_l(fm_l), .fm_r(fm_r)
   );

   function automatic logic m_remap();
      return ifm_on & mext[4][0];
   endfunction

   function automatic logic [7:0] m_read(input logic sp, input int idx);
      if (sp) return (idx < 8) ? mext[idx] : 8'h00;
      if (m_remap() && idx == 18) return mext[6];
      if (m_remap() && idx == 19) return mext[7];
      return mleg[idx];
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string otag);
      check({otag, " remap_on R2"}, {7'b0, remap_on}, {7'b0, m_remap()});
      check({otag, " line_l R6"}, line_l, m_remap() ? mext[0] : mleg[18]);
      check({otag, " line_r R6"}, line_r, m_remap() ? mext[1] : mleg[19]);
      check({otag, " aux_l R6"}, aux_l, mleg[18]);
      check({otag, " aux_r R6"}, aux_r, mleg[19]);
      check({otag, " fm_l R5"}, fm_l, mext[6]);
      check({otag, " fm_r R5"}, fm_r, mext[7]);
      for (int sp = 0; sp < 2; sp++) begin
         for (int i = 0; i < 32; i++) begin
            rd_space = sp[0];
            rd_idx   = i[4:0];
            #1;
            check((sp == 1 && i >= 8) ? "readback R8" : "readback R7",
                  rd_data, m_read(sp[0], i));
         end
      end
   endtask

   // write that is visible after one edge (R10)
   task automatic do_wr(input logic sp, input int idx, input logic [7:0] d);
      logic rm;
      @(negedge clk);
      wr_en = 1'b1; wr_space = sp; wr_idx = idx[4:0]; wr_data = d;
      rm = m_remap();
      @(posedge clk);
      if (sp) begin
         if (idx < 8) mext[idx] = d;
      end else if (rm && idx == 18) mext[6] = d;
      else if (rm && idx == 19) mext[7] = d;
      else mleg[idx] = d;
      #1;
      wr_en = 1'b0;
      check_all("after write R10");
   endtask

   task automatic set_mode(input logic f, input logic [7:0] x4);
      @(negedge clk);
      ifm_on = f;
      do_wr(1'b1, 4, x4);
      check("mode R9", {7'b0, remap_on}, {7'b0, f & x4[0]});
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mleg[i] = (i == 18 || i == 19) ? 8'h9F : 8'h00;
      for (int i = 0; i < 8; i++)
         mext[i] = (i == 0 || i == 1 || i == 6 || i == 7) ? 8'h9F : 8'h00;
      repeat (3) @(posedge clk);
      #1;
      check("reset aux R1", aux_l, 8'h9F);
      check("reset fm R1", fm_r, 8'h9F);
      check_all("reset R1");
      @(negedge clk);
      rst_n = 1'b1;

      for (int mode = 0; mode < 6; mode++) begin
         logic [7:0] x4v;
         logic fv;
         fv  = mode[0];
         x4v = (mode >= 4) ? 8'hFE : {7'b0, mode[1]};
         set_mode(fv, x4v);
         // distinct pair values on the steered indices
         do_wr(1'b0, 18, 8'h10 + 8'(mode));
         if (m_remap()) begin
            check("steer left R3", fm_l, 8'h10 + 8'(mode));
            check("legacy kept R3", aux_l, mleg[18]);
         end else begin
            check("direct left R4", aux_l, 8'h10 + 8'(mode));
         end
         do_wr(1'b0, 19, 8'h20 + 8'(mode));
         if (m_remap()) check("steer right R3", fm_r, 8'h20 + 8'(mode));
         else           check("direct right R4", aux_r, 8'h20 + 8'(mode));
         do_wr(1'b1, 6, 8'hA0 + 8'(mode));
         check("ext fm R5", fm_l, 8'hA0 + 8'(mode));
         do_wr(1'b1, 0, 8'h30 + 8'(mode));
         do_wr(1'b1, 1, 8'h40 + 8'(mode));
         do_wr(1'b1, 20, 8'h55);
         do_wr(1'b1, 9, 8'hAA);
         for (int i = 0; i < 32; i++)
            do_wr(1'b0, i, 8'(i * 7 + mode * 3));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule